// File: doc/BRIEF.md
# Two-Level Distributed Event Counter

This block counts performance events across a set of local monitors and one central controller. Each local monitor has four 16-bit counters. Each counter watches one of eight event lines belonging to that monitor. A local counter never reports its value as an event count. Only its wraps matter: each wrap from all ones to zero is passed on as a single increment to one of eight 32-bit global counters in the controller. Which global counter receives it is set by a target field in the local counter's configuration.

The controller does the following:
- It holds the run bit that gates all counting.
- It accumulates the forwarded wraps. Several wraps that reach the same global counter in one cycle are all counted.
- It keeps a cycle counter.
- It can place any global counter in cycle mode. In that mode the counter advances once per running cycle and ignores local wraps.
- When a global counter wraps, it latches a sticky status bit. The interrupt is the OR of the status bits that are enabled by a mask.

Software reaches every register through a flat write-strobe and combinational-read port. Status bits are cleared by writing 1 to them.

Top module: `evt_mesh_pmu`

## Requirements
- R1: After reset, all of the following read as zero: the run bit, status, mask, cycle-mode bits, cycle counter, every global counter, every local configuration and every local counter. The interrupt output is low.
- R2: Local counter n = monitor*4 + k is configured at address 0x40+n.
  - Bit 0 is the enable.
  - Bits 3:1 select the event line, where line = port*4 + channel; monitor m's line j is mon_evt[m*8+j].
  - Bits 6:4 select the target global counter.
  - Higher bits read as zero.
  - While run is set and the enable is set, the counter at 0x80+n rises by one for every clock edge on which the selected line is high.
- R3: A local counter whose enable bit is clear does not change, even when its selected line pulses. A pulse on a line that no counter selects has no effect.
- R4: While the run bit (address 0x00, bit 0) is clear, no counter changes: not the local counters, not the global counters, and not the cycle counter at 0x04.
- R5: When a local counter wraps from 0xFFFF to 0, the target global counter rises by one at the following clock edge.
- R6: Local wraps that reach the same global counter in the same cycle are all added to it.
- R7: A wrap of global counter g (address 0x08+g) sets bit g of the status register at 0x01. The bit stays set until 1 is written to that bit. Writing 1 to other bits leaves it set.
- R8: The interrupt output is high exactly when some status bit and the matching bit of the mask register at 0x02 are both set.
- R9: Setting bit g of the cycle-mode register at 0x03 makes global counter g rise by one on every running clock edge. The cycle counter at 0x04 rises by one on every running clock edge.
- R10: Writing 0x08+g loads global counter g. Writing 0x80+n loads local counter n from the low 16 data bits. The written value reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_evt | input | N_MON*8 | Event lines, eight per local monitor |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| irq | output | 1 | Global overflow interrupt |

## Verification
Two local wraps can reach the same global counter on the same edge. Global accumulation must then add both in one step. The bench provokes this by preloading two counters in different monitors to 0xFFFF. Both target global counter 2, and the bench pulses their lines together on one edge. It then judges that the global counter moved by exactly two and that neither wrap set a status bit. A second case places a status clear next to a live status bit: writing 1 to an unrelated bit must leave both the bit and the interrupt asserted.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int LCL_PER_MON = 4;
    localparam int SRC_LINES   = 8;
    localparam int SRC_W       = $clog2(SRC_LINES);
    localparam int N_GLB       = 8;
    localparam int GSEL_W      = $clog2(N_GLB);
    localparam int REG_AW      = 8;

    // local counter configuration: target[6:4], line[3:1], enable[0]
    typedef struct packed {
        logic [GSEL_W-1:0] tgt;
        logic [SRC_W-1:0]  src;
        logic              en;
    } lcfg_t;

    localparam int LCFG_W = $bits(lcfg_t);

    localparam logic [REG_AW-1:0] A_CTRL = 8'h00;
    localparam logic [REG_AW-1:0] A_STS  = 8'h01;
    localparam logic [REG_AW-1:0] A_MASK = 8'h02;
    localparam logic [REG_AW-1:0] A_CYCM = 8'h03;
    localparam logic [REG_AW-1:0] A_CYC  = 8'h04;
    localparam logic [REG_AW-1:0] A_GLB  = 8'h08;
    localparam logic [REG_AW-1:0] A_LCFG = 8'h40;
    localparam logic [REG_AW-1:0] A_LCNT = 8'h80;
endpackage

// File: rtl/pmu_local_mon.sv
module pmu_local_mon
    import pmu_pkg::*;
#(
    parameter int LCL_W = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  run,
    input  logic [SRC_LINES-1:0]                  evt,
    input  lcfg_t [LCL_PER_MON-1:0]               cfg,
    input  logic [LCL_PER_MON-1:0]                cnt_wr,
    input  logic [LCL_W-1:0]                      wdata,
    output logic [LCL_PER_MON-1:0][LCL_W-1:0]     cnt,
    output logic [LCL_PER_MON-1:0]                ovf
);
    typedef struct packed {
        logic [LCL_PER_MON-1:0][LCL_W-1:0] cnt;
        logic [LCL_PER_MON-1:0]            ovf;
    } mon_st_t;

    mon_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < LCL_PER_MON; k++) begin
            st_d.ovf[k] = 1'b0;
            if (cnt_wr[k]) begin
                st_d.cnt[k] = wdata;
            end else if (run && cfg[k].en && evt[cfg[k].src]) begin
                st_d.cnt[k] = st_q.cnt[k] + 1'b1;
                st_d.ovf[k] = &st_q.cnt[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;
endmodule

// File: rtl/pmu_global_bank.sv
module pmu_global_bank
    import pmu_pkg::*;
#(
    parameter int N_LCL = 8,
    parameter int GLB_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              run,
    input  logic [N_LCL-1:0]                  ovf,
    input  lcfg_t [N_LCL-1:0]                 cfg,
    input  logic [N_GLB-1:0]                  cyc_mode,
    input  logic [N_GLB-1:0]                  mask,
    input  logic [N_GLB-1:0]                  cnt_wr,
    input  logic [GLB_W-1:0]                  wdata,
    input  logic [N_GLB-1:0]                  sts_clr,
    output logic [N_GLB-1:0][GLB_W-1:0]       cnt,
    output logic [N_GLB-1:0]                  sts,
    output logic [GLB_W-1:0]                  cyc,
    output logic                              irq
);
    localparam int INC_W = $clog2(N_LCL + 1);

    typedef struct packed {
        logic [N_GLB-1:0][GLB_W-1:0] cnt;
        logic [N_GLB-1:0]            sts;
        logic [GLB_W-1:0]            cyc;
    } glb_st_t;

    glb_st_t st_d, st_q;

    always_comb begin
        logic [INC_W-1:0] inc;
        logic [GLB_W:0]   sum;
        st_d = st_q;
        for (int g = 0; g < N_GLB; g++) begin
            inc = '0;
            if (run) begin
                if (cyc_mode[g]) begin
                    inc = INC_W'(1);
                end else begin
                    for (int l = 0; l < N_LCL; l++) begin
                        inc = inc + INC_W'(ovf[l] && (cfg[l].tgt == GSEL_W'(g)));
                    end
                end
            end
            sum = {1'b0, st_q.cnt[g]} + {{(GLB_W + 1 - INC_W){1'b0}}, inc};
            st_d.sts[g] = st_q.sts[g] & ~sts_clr[g];
            if (cnt_wr[g]) begin
                st_d.cnt[g] = wdata;
            end else begin
                st_d.cnt[g] = sum[GLB_W-1:0];
                if (sum[GLB_W]) st_d.sts[g] = 1'b1;
            end
        end
        if (run) st_d.cyc = st_q.cyc + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign sts = st_q.sts;
    assign cyc = st_q.cyc;
    assign irq = |(st_q.sts & mask);
endmodule

// File: rtl/pmu_csr.sv
module pmu_csr
    import pmu_pkg::*;
#(
    parameter int N_LCL  = 8,
    parameter int LCL_W  = 16,
    parameter int GLB_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic                          reg_wr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    input  logic [N_LCL-1:0][LCL_W-1:0]   lcnt,
    input  logic [N_GLB-1:0][GLB_W-1:0]   gcnt,
    input  logic [N_GLB-1:0]              sts,
    input  logic [GLB_W-1:0]              cyc,
    output logic                          run,
    output logic [N_GLB-1:0]              mask,
    output logic [N_GLB-1:0]              cyc_mode,
    output lcfg_t [N_LCL-1:0]             lcfg,
    output logic [N_LCL-1:0]              lcnt_wr,
    output logic [N_GLB-1:0]              gcnt_wr,
    output logic [N_GLB-1:0]              sts_clr
);
    typedef struct packed {
        logic                 run;
        logic [N_GLB-1:0]     mask;
        logic [N_GLB-1:0]     cycm;
        lcfg_t [N_LCL-1:0]    lcfg;
    } csr_st_t;

    csr_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        lcnt_wr = '0;
        gcnt_wr = '0;
        sts_clr = '0;
        if (reg_wr) begin
            if (reg_addr == A_CTRL) st_d.run  = reg_wdata[0];
            if (reg_addr == A_MASK) st_d.mask = reg_wdata[N_GLB-1:0];
            if (reg_addr == A_CYCM) st_d.cycm = reg_wdata[N_GLB-1:0];
            if (reg_addr == A_STS)  sts_clr   = reg_wdata[N_GLB-1:0];
            for (int g = 0; g < N_GLB; g++) begin
                if (reg_addr == A_GLB + REG_AW'(g)) gcnt_wr[g] = 1'b1;
            end
            for (int l = 0; l < N_LCL; l++) begin
                if (reg_addr == A_LCFG + REG_AW'(l)) st_d.lcfg[l] = reg_wdata[LCFG_W-1:0];
                if (reg_addr == A_LCNT + REG_AW'(l)) lcnt_wr[l]   = 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) reg_rdata = DATA_W'(st_q.run);
        if (reg_addr == A_STS)  reg_rdata = DATA_W'(sts);
        if (reg_addr == A_MASK) reg_rdata = DATA_W'(st_q.mask);
        if (reg_addr == A_CYCM) reg_rdata = DATA_W'(st_q.cycm);
        if (reg_addr == A_CYC)  reg_rdata = DATA_W'(cyc);
        for (int g = 0; g < N_GLB; g++) begin
            if (reg_addr == A_GLB + REG_AW'(g)) reg_rdata = DATA_W'(gcnt[g]);
        end
        for (int l = 0; l < N_LCL; l++) begin
            if (reg_addr == A_LCFG + REG_AW'(l)) reg_rdata = DATA_W'(st_q.lcfg[l]);
            if (reg_addr == A_LCNT + REG_AW'(l)) reg_rdata = DATA_W'(lcnt[l]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run      = st_q.run;
    assign mask     = st_q.mask;
    assign cyc_mode = st_q.cycm;
    assign lcfg     = st_q.lcfg;
endmodule

// File: rtl/evt_mesh_pmu.sv
module evt_mesh_pmu
    import pmu_pkg::*;
#(
    parameter int N_MON  = 2,
    parameter int LCL_W  = 16,
    parameter int GLB_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_MON*SRC_LINES-1:0] mon_evt,
    input  logic [REG_AW-1:0]          reg_addr,
    input  logic                       reg_wr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic                       irq
);
    localparam int N_LCL = N_MON * LCL_PER_MON;

    logic                          run;
    logic [N_GLB-1:0]              mask;
    logic [N_GLB-1:0]              cyc_mode;
    lcfg_t [N_LCL-1:0]             lcfg;
    logic [N_LCL-1:0]              lcnt_wr;
    logic [N_GLB-1:0]              gcnt_wr;
    logic [N_GLB-1:0]              sts_clr;
    logic [N_LCL-1:0][LCL_W-1:0]   lcnt;
    logic [N_LCL-1:0]              lcl_ovf;
    logic [N_GLB-1:0][GLB_W-1:0]   gcnt;
    logic [N_GLB-1:0]              sts;
    logic [GLB_W-1:0]              cyc_cnt;

    pmu_csr #(.N_LCL(N_LCL), .LCL_W(LCL_W), .GLB_W(GLB_W), .DATA_W(DATA_W)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lcnt(lcnt), .gcnt(gcnt), .sts(sts), .cyc(cyc_cnt),
        .run(run), .mask(mask), .cyc_mode(cyc_mode), .lcfg(lcfg),
        .lcnt_wr(lcnt_wr), .gcnt_wr(gcnt_wr), .sts_clr(sts_clr)
    );

    for (genvar m = 0; m < N_MON; m++) begin : g_mon
        pmu_local_mon #(.LCL_W(LCL_W)) u_mon (
            .clk(clk), .rst_n(rst_n), .run(run),
            .evt(mon_evt[m*SRC_LINES +: SRC_LINES]),
            .cfg(lcfg[m*LCL_PER_MON +: LCL_PER_MON]),
            .cnt_wr(lcnt_wr[m*LCL_PER_MON +: LCL_PER_MON]),
            .wdata(reg_wdata[LCL_W-1:0]),
            .cnt(lcnt[m*LCL_PER_MON +: LCL_PER_MON]),
            .ovf(lcl_ovf[m*LCL_PER_MON +: LCL_PER_MON])
        );
    end

    pmu_global_bank #(.N_LCL(N_LCL), .GLB_W(GLB_W)) u_glb (
        .clk(clk), .rst_n(rst_n), .run(run),
        .ovf(lcl_ovf), .cfg(lcfg), .cyc_mode(cyc_mode), .mask(mask),
        .cnt_wr(gcnt_wr), .wdata(reg_wdata[GLB_W-1:0]), .sts_clr(sts_clr),
        .cnt(gcnt), .sts(sts), .cyc(cyc_cnt), .irq(irq)
    );
endmodule

// File: rtl/pmu_chk.sv
module pmu_chk
    import pmu_pkg::*;
#(
    parameter int N_LCL = 8,
    parameter int LCL_W = 16,
    parameter int GLB_W = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        run,
    input logic                        reg_wr,
    input logic                        irq,
    input logic [N_GLB-1:0]            sts,
    input logic [N_GLB-1:0]            sts_clr,
    input logic [N_LCL-1:0]            ovf,
    input logic [N_LCL-1:0][LCL_W-1:0] lcnt,
    input logic [GLB_W-1:0]            cyc
);
    // R7
    sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ~sts_clr) != '0) |=> (($past(sts & ~sts_clr) & ~sts) == '0));

    // R8
    no_irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts == '0) |-> !irq);

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reg_wr) |=> $stable(lcnt));

    // R9
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cyc == $past(cyc) + GLB_W'(1)));

    for (genvar l = 0; l < N_LCL; l++) begin : g_lcl
        // R5
        ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[l] |-> (lcnt[l] == '0));
        // R5
        ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[l] |=> !ovf[l]);
    end
endmodule

bind evt_mesh_pmu pmu_chk #(.N_LCL(N_LCL), .LCL_W(LCL_W), .GLB_W(GLB_W)) u_pmu_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .reg_wr(reg_wr), .irq(irq),
    .sts(sts), .sts_clr(sts_clr), .ovf(lcl_ovf), .lcnt(lcnt), .cyc(cyc_cnt)
);

// File: tb/test_evt_mesh_pmu.sv
`timescale 1ns/1ps
module test_evt_mesh_pmu;
    localparam int N_MON = 2;
    localparam int NV    = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_MON*8-1:0] mon_evt = '0;
    logic [7:0]        reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    evt_mesh_pmu #(.N_MON(N_MON)) i_evt_mesh_pmu (
        .clk(clk), .rst_n(rst_n), .mon_evt(mon_evt), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // {write, address, data}; a read entry compares data with the read-back
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 8'h40, 32'h0000_00FF}, {1'b0, 8'h40, 32'h0000_007F},
        {1'b1, 8'h02, 32'h0000_01FF}, {1'b0, 8'h02, 32'h0000_00FF},
        {1'b1, 8'h0A, 32'hDEAD_BEEF}, {1'b0, 8'h0A, 32'hDEAD_BEEF},
        {1'b1, 8'h81, 32'h0001_2345}, {1'b0, 8'h81, 32'h0000_2345},
        {1'b1, 8'h03, 32'h0000_0000}, {1'b0, 8'h03, 32'h0000_0000},
        {1'b1, 8'h40, 32'h0000_0000}, {1'b0, 8'h40, 32'h0000_0000},
        {1'b1, 8'h02, 32'h0000_0000}, {1'b1, 8'h0A, 32'h0000_0000},
        {1'b0, 8'h0A, 32'h0000_0000}, {1'b1, 8'h81, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic pulse(input logic [N_MON*8-1:0] lines, input int n);
        @(negedge clk);
        mon_evt = lines;
        repeat (n) @(posedge clk);
        #1;
        mon_evt = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] c0, c1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd("R1 ctrl", 8'h00, 0);
        rd("R1 status", 8'h01, 0);
        rd("R1 cycle", 8'h04, 0);
        rd("R1 global0", 8'h08, 0);
        rd("R1 lcfg0", 8'h40, 0);
        rd("R1 lcnt0", 8'h80, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 / R10 register vectors
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:0]);
            else            rd("R2/R10 vector", VEC[i][39:32], VEC[i][31:0]);
        end

        // R2 counting of the selected line, R3 disabled counter
        wr(8'h40, 32'h15);           // line 2, target 1, enabled
        wr(8'h41, 32'h04);           // line 2, disabled
        wr(8'h00, 32'h1);
        pulse(16'h0004, 5);
        pulse(16'h0008, 3);          // line 3: not selected
        wr(8'h00, 32'h0);
        rd("R2 count", 8'h80, 5);
        rd("R3 disabled", 8'h81, 0);

        // R4 run clear halts everything
        pulse(16'h0004, 4);
        rd("R4 local hold", 8'h80, 5);
        @(negedge clk); reg_addr = 8'h04; #1; c0 = reg_rdata;
        idle(3);
        rd("R4 cycle hold", 8'h04, c0);

        // R5 wrap forwarding
        wr(8'h80, 32'hFFFE);
        wr(8'h09, 32'h0);
        wr(8'h00, 32'h1);
        pulse(16'h0004, 3);
        wr(8'h00, 32'h0);
        rd("R5 global1", 8'h09, 1);
        rd("R5 local after wrap", 8'h80, 1);

        // R6 two wraps into one global counter in the same cycle
        wr(8'h40, 32'h25);
        wr(8'h44, 32'h21);
        wr(8'h80, 32'hFFFF);
        wr(8'h84, 32'hFFFF);
        wr(8'h0A, 32'h0);
        wr(8'h00, 32'h1);
        pulse(16'h0104, 1);
        idle(2);
        wr(8'h00, 32'h0);
        rd("R6 global2", 8'h0A, 2);
        rd("R6 no status", 8'h01, 0);
        rd("R5 local4 wrapped", 8'h84, 0);

        // R7 / R8 global wrap, sticky status, interrupt
        wr(8'h41, 32'h31);
        wr(8'h81, 32'hFFFF);
        wr(8'h0B, 32'hFFFF_FFFF);
        wr(8'h00, 32'h1);
        pulse(16'h0001, 1);
        idle(2);
        wr(8'h00, 32'h0);
        rd("R7 global3 wrapped", 8'h0B, 0);
        rd("R7 status set", 8'h01, 32'h08);
        chk("R8 masked irq", {31'b0, irq}, 0);
        wr(8'h02, 32'h08);
        chk("R8 irq on", {31'b0, irq}, 1);
        wr(8'h01, 32'h01);
        rd("R7 other clear", 8'h01, 32'h08);
        chk("R8 irq kept", {31'b0, irq}, 1);
        wr(8'h01, 32'h08);
        rd("R7 cleared", 8'h01, 0);
        chk("R8 irq off", {31'b0, irq}, 0);

        // R9 cycle mode and cycle counter
        wr(8'h03, 32'h20);
        wr(8'h0D, 32'h0);
        @(negedge clk); reg_addr = 8'h04; #1; c0 = reg_rdata;
        wr(8'h00, 32'h1);
        idle(10);
        wr(8'h00, 32'h0);
        rd("R9 cycle-mode global5", 8'h0D, 11);
        @(negedge clk); reg_addr = 8'h04; #1; c1 = reg_rdata;
        chk("R9 cycle counter", c1 - c0, 11);
        idle(3);
        rd("R4 global hold", 8'h0D, 11);

        done = 1'b1;
        finish_run();
    end
endmodule